// File: doc/BRIEF.md
# Pushbuffer Command Enqueue Unit

This unit sits between the parser of a graphics command channel and the command queue that feeds the execution engines. The parser hands it data words one at a time. It also loads the current method address, the subchannel and an address-hold flag whenever it decodes a new command header. For every data word it accepts, the unit places one command entry into a registered output slot. The entry carries the method address, the subchannel, the hold flag and the 32-bit word. The slot drains into the downstream queue over a valid/ready handshake. After each accepted word the method address steps forward by 4, unless the hold flag is set.

The parser also drives an error code. When that code moves from zero to a nonzero value, the unit stops accepting words and latches a pending interrupt. It stays stopped until software clears the suspension through the register port. Software can also read the enables, the status, the interrupt bit and a copy of the last accepted data word through that port.

Top module: `pbq_enqueue`

## Requirements
- R1: A word is accepted in a cycle where `word_valid` and `word_ready` are both high. After that clock edge, `cmd_valid` is high and `cmd_method`, `cmd_sub`, `cmd_hold` and `cmd_param` hold the method state that applied during the accepting cycle, together with the accepted word.
- R2: Each accepted word advances the 14-bit method address by 4, wrapping modulo 2^14, when the hold flag is 0. When the hold flag is 1, the address stays the same.
- R3: `word_ready` is high only when all of these hold: the push enable (register 0 bit 0) is 1, the access enable (register 1 bit 0) is 1, the unit is not suspended, `method_load` is low, and the output slot is empty or `cmd_ready` is high. A word offered at any other time is ignored: no entry is made and the shadow word keeps its value.
- R4: An error event occurs in a cycle where `err_code` is nonzero and was zero in the previous cycle (it counts as zero during reset). After that edge, the unit is suspended and the interrupt pending bit is set.
- R5: Register 1 reads back the access enable in bit 0, slot-empty (no entry held in the output slot) in bit 8, and the suspended flag in bit 12. All other bits read 0.
- R6: A write to register 1 loads the access enable from bit 0. It clears the suspension when bit 12 is 0 and forces suspension when bit 12 is 1.
- R7: Register 3 reads back the most recently accepted data word.
- R8: The interrupt pending bit (register 2 bit 0, also driven on `irq`) stays set until a write to register 2 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it unchanged.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the entry on the output is held stable, no word is accepted and the method address does not move.
- R10: Reset (synchronous, active high) leaves the method address, subchannel and hold flag at 0, the unit not suspended, the interrupt clear, both enables off, the output slot empty and the shadow word 0.
- R11: An error event takes priority over a same-cycle software write that clears the suspension or the interrupt bit.
- R12: `method_load` loads the method address, subchannel and hold flag for the next accepted word, and it forces `word_ready` low in the cycle it is high.
- R13: `reg_rdata` shows, one cycle after `reg_addr` is presented, the selected register as it stood before that clock edge. Register 0 holds the push enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A data word is offered |
| word_data | input | 32 | Offered data word |
| word_ready | output | 1 | The offered word is taken at this edge |
| method_load | input | 1 | Load new method state from the header parser |
| load_method | input | 14 | Method address to load |
| load_sub | input | 3 | Subchannel to load |
| load_hold | input | 1 | Address-hold flag to load |
| err_code | input | 3 | Parser error code, zero when there is no error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Pusher interrupt pending |
| cmd_valid | output | 1 | The output slot holds an entry |
| cmd_ready | input | 1 | The queue takes the entry |
| cmd_method | output | 14 | Entry method address |
| cmd_sub | output | 3 | Entry subchannel |
| cmd_hold | output | 1 | Entry address-hold flag |
| cmd_param | output | 32 | Entry parameter word |

## Verification
`word_ready` is a same-cycle function of state and inputs, so the bench samples it one time unit after driving inputs on the falling edge, before the rising edge. All other results land one edge later. An accepted word shows up on the `cmd_*` outputs, an error event shows up on `irq` and in the suspended bit, and a register read shows up on `reg_rdata` after the next rising edge. The bench therefore samples these one time unit after that edge and compares them with a model. The model's next state is computed from the requirements, and its read value is taken from the state before the edge. Directed steps cover address wrap, hold, backpressure, error priority and the interrupt clear, and a seeded random phase mixes all inputs.

// File: rtl/pbq_pkg.sv
package pbq_pkg;
  localparam int METH_W = 14;
  localparam int SUB_W  = 3;
  localparam int DATA_W = 32;
  localparam int RADDR_W = 2;

  localparam logic [RADDR_W-1:0] REG_CHAN   = 2'd0;
  localparam logic [RADDR_W-1:0] REG_PUSH   = 2'd1;
  localparam logic [RADDR_W-1:0] REG_IRQ    = 2'd2;
  localparam logic [RADDR_W-1:0] REG_SHADOW = 2'd3;

  localparam int PUSH_ACC_BIT   = 0;
  localparam int PUSH_EMPTY_BIT = 8;
  localparam int PUSH_SUSP_BIT  = 12;

  typedef struct packed {
    logic [METH_W-1:0] method;
    logic [SUB_W-1:0]  sub;
    logic              hold;
    logic [DATA_W-1:0] param;
  } cmd_entry_t;
endpackage

// File: rtl/pbq_method_track.sv
module pbq_method_track #(
  parameter int MW   = 14,
  parameter int SW   = 3,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [MW-1:0] load_addr,
  input  logic [SW-1:0] load_sub,
  input  logic          load_hold,
  input  logic          advance,
  output logic [MW-1:0] method,
  output logic [SW-1:0] sub,
  output logic          hold
);
  localparam logic [MW-1:0] STEP_V = MW'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      method <= '0;
      sub    <= '0;
      hold   <= 1'b0;
    end else if (load) begin
      method <= load_addr;
      sub    <= load_sub;
      hold   <= load_hold;
    end else if (advance && !hold) begin
      method <= method + STEP_V;
    end
  end
endmodule

// File: rtl/pbq_ctrl_regs.sv
module pbq_ctrl_regs
  import pbq_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [ERR_W-1:0]   err_code,
  input  logic               accept,
  input  logic [DATA_W-1:0]  word_data,
  input  logic               slot_full,
  output logic               push_en,
  output logic               acc_en,
  output logic               suspended,
  output logic               irq_pend,
  output logic [DATA_W-1:0]  reg_rdata
);
  logic              err_zero_q;
  logic              err_event;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] push_view;

  assign err_event = (err_code != '0) && err_zero_q;

  always_ff @(posedge clk) begin
    if (rst) err_zero_q <= 1'b1;
    else     err_zero_q <= (err_code == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      push_en <= 1'b0;
      acc_en  <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == REG_CHAN) push_en <= reg_wdata[0];
      if (reg_addr == REG_PUSH) acc_en  <= reg_wdata[PUSH_ACC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      suspended <= 1'b0;
    else if (err_event)
      suspended <= 1'b1;
    else if (reg_wr && reg_addr == REG_PUSH)
      suspended <= reg_wdata[PUSH_SUSP_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_pend <= 1'b0;
    else if (err_event)
      irq_pend <= 1'b1;
    else if (reg_wr && reg_addr == REG_IRQ && reg_wdata[0])
      irq_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         shadow_q <= '0;
    else if (accept) shadow_q <= word_data;
  end

  always_comb begin
    push_view = '0;
    push_view[PUSH_ACC_BIT]   = acc_en;
    push_view[PUSH_EMPTY_BIT] = !slot_full;
    push_view[PUSH_SUSP_BIT]  = suspended;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        REG_CHAN:   reg_rdata <= {{(DATA_W-1){1'b0}}, push_en};
        REG_PUSH:   reg_rdata <= push_view;
        REG_IRQ:    reg_rdata <= {{(DATA_W-1){1'b0}}, irq_pend};
        default:    reg_rdata <= shadow_q;
      endcase
    end
  end
endmodule

// File: rtl/pbq_out_stage.sv
module pbq_out_stage
  import pbq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fill,
  input  cmd_entry_t entry_in,
  input  logic       pop,
  output logic       valid,
  output cmd_entry_t entry
);
  always_ff @(posedge clk) begin
    if (rst)       valid <= 1'b0;
    else if (fill) valid <= 1'b1;
    else if (pop)  valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)       entry <= '0;
    else if (fill) entry <= entry_in;
  end
endmodule

// File: rtl/pbq_enqueue.sv
module pbq_enqueue
  import pbq_pkg::*;
#(
  parameter int ERR_W       = 3,
  parameter int METHOD_STEP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [DATA_W-1:0]  word_data,
  output logic               word_ready,
  input  logic               method_load,
  input  logic [METH_W-1:0]  load_method,
  input  logic [SUB_W-1:0]   load_sub,
  input  logic               load_hold,
  input  logic [ERR_W-1:0]   err_code,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [METH_W-1:0]  cmd_method,
  output logic [SUB_W-1:0]   cmd_sub,
  output logic               cmd_hold,
  output logic [DATA_W-1:0]  cmd_param
);
  logic              push_en, acc_en, suspended;
  logic              accept;
  logic [METH_W-1:0] cur_method;
  logic [SUB_W-1:0]  cur_sub;
  logic              cur_hold;
  cmd_entry_t        new_entry, out_entry;

  assign word_ready = push_en && acc_en && !suspended && !method_load
                      && (!cmd_valid || cmd_ready);
  assign accept     = word_valid && word_ready;

  pbq_method_track #(.MW(METH_W), .SW(SUB_W), .STEP(METHOD_STEP)) u_track (
    .clk(clk), .rst(rst),
    .load(method_load), .load_addr(load_method), .load_sub(load_sub),
    .load_hold(load_hold), .advance(accept),
    .method(cur_method), .sub(cur_sub), .hold(cur_hold)
  );

  pbq_ctrl_regs #(.ERR_W(ERR_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .err_code(err_code), .accept(accept), .word_data(word_data),
    .slot_full(cmd_valid),
    .push_en(push_en), .acc_en(acc_en), .suspended(suspended),
    .irq_pend(irq), .reg_rdata(reg_rdata)
  );

  always_comb begin
    new_entry.method = cur_method;
    new_entry.sub    = cur_sub;
    new_entry.hold   = cur_hold;
    new_entry.param  = word_data;
  end

  pbq_out_stage u_out (
    .clk(clk), .rst(rst),
    .fill(accept), .entry_in(new_entry), .pop(cmd_ready),
    .valid(cmd_valid), .entry(out_entry)
  );

  assign cmd_method = out_entry.method;
  assign cmd_sub    = out_entry.sub;
  assign cmd_hold   = out_entry.hold;
  assign cmd_param  = out_entry.param;
endmodule

// File: rtl/pbq_enqueue_chk.sv
module pbq_enqueue_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             word_valid,
  input logic             word_ready,
  input logic [31:0]      word_data,
  input logic             method_load,
  input logic [ERR_W-1:0] err_code,
  input logic             irq,
  input logic             suspended,
  input logic             cur_hold,
  input logic [13:0]      cur_method,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [13:0]      cmd_method,
  input logic [2:0]       cmd_sub,
  input logic             cmd_hold,
  input logic [31:0]      cmd_param
);
  logic prev_zero;
  always_ff @(posedge clk) begin
    if (rst) prev_zero <= 1'b1;
    else     prev_zero <= (err_code == '0);
  end

  a_r1_entry_param: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> (cmd_valid && cmd_param == $past(word_data)));

  a_r2_method_step: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready && !cur_hold) |=> (cur_method == $past(cur_method) + 14'd4));

  a_r3_no_push_suspended: assert property (@(posedge clk) disable iff (rst)
    word_ready |-> !suspended);

  a_r4_error_suspends: assert property (@(posedge clk) disable iff (rst)
    (err_code != '0 && prev_zero) |=> (suspended && irq));

  a_r9_hold_entry: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_method) && $stable(cmd_sub)
                                   && $stable(cmd_hold) && $stable(cmd_param)));

  a_r12_load_blocks: assert property (@(posedge clk) disable iff (rst)
    method_load |-> !word_ready);
endmodule

bind pbq_enqueue pbq_enqueue_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .method_load(method_load), .err_code(err_code),
  .irq(irq), .suspended(suspended), .cur_hold(cur_hold), .cur_method(cur_method),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_method(cmd_method),
  .cmd_sub(cmd_sub), .cmd_hold(cmd_hold), .cmd_param(cmd_param)
);

// File: tb/pbq_enqueue_test.sv
module pbq_enqueue_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic        method_load = 1'b0;
  logic [13:0] load_method = '0;
  logic [2:0]  load_sub = '0;
  logic        load_hold = 1'b0;
  logic [2:0]  err_code = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [13:0] cmd_method;
  logic [2:0]  cmd_sub;
  logic        cmd_hold;
  logic [31:0] cmd_param;

  pbq_enqueue uut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .method_load(method_load), .load_method(load_method),
    .load_sub(load_sub), .load_hold(load_hold), .err_code(err_code),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_method(cmd_method), .cmd_sub(cmd_sub), .cmd_hold(cmd_hold),
    .cmd_param(cmd_param)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  bit        m_pe, m_ae, m_susp, m_irq, m_mv, m_hold, m_prevz;
  bit [13:0] m_meth;
  bit [2:0]  m_sub;
  bit [31:0] m_shadow;
  bit [13:0] e_meth;
  bit [2:0]  e_sub;
  bit        e_hold;
  bit [31:0] e_param;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] model_read(input bit [1:0] a);
    case (a)
      2'd0: return {31'd0, m_pe};
      2'd1: return (32'(m_susp) << 12) | (32'(!m_mv) << 8) | 32'(m_ae);
      2'd2: return {31'd0, m_irq};
      default: return m_shadow;
    endcase
  endfunction

  function automatic bit model_ready(input bit ld, input bit rdy);
    return m_pe && m_ae && !m_susp && !ld && (!m_mv || rdy);
  endfunction

  task automatic model_reset();
    m_pe = 0; m_ae = 0; m_susp = 0; m_irq = 0; m_mv = 0; m_hold = 0; m_prevz = 1;
    m_meth = 0; m_sub = 0; m_shadow = 0;
    e_meth = 0; e_sub = 0; e_hold = 0; e_param = 0;
  endtask

  // one clock cycle: drive at falling edge, check ready, step model, check results
  task automatic cyc(input bit wv, input bit [31:0] wd, input bit ld,
                     input bit [13:0] la, input bit [2:0] ls, input bit lh,
                     input bit [2:0] ec, input bit wr, input bit [1:0] ad,
                     input bit [31:0] wdat, input bit rdy);
    bit acc, ev;
    bit [31:0] exp_rd;
    @(negedge clk);
    word_valid = wv; word_data = wd; method_load = ld; load_method = la;
    load_sub = ls; load_hold = lh; err_code = ec; reg_wr = wr; reg_addr = ad;
    reg_wdata = wdat; cmd_ready = rdy;
    #1;
    check(word_ready === model_ready(ld, rdy), "R3 word_ready gating",
          32'(word_ready), 32'(model_ready(ld, rdy)));
    acc = wv && model_ready(ld, rdy);
    ev = (ec != 0) && m_prevz;
    exp_rd = model_read(ad);
    if (acc) begin
      m_mv = 1; e_meth = m_meth; e_sub = m_sub; e_hold = m_hold; e_param = wd;
      m_shadow = wd;
    end else if (rdy) m_mv = 0;
    if (ld) begin m_meth = la; m_sub = ls; m_hold = lh; end
    else if (acc && !m_hold) m_meth = m_meth + 14'd4;
    if (wr) begin
      if (ad == 2'd0) m_pe = wdat[0];
      if (ad == 2'd1) begin m_ae = wdat[0]; m_susp = wdat[12]; end
      if (ad == 2'd2 && wdat[0]) m_irq = 0;
    end
    if (ev) begin m_susp = 1; m_irq = 1; end
    m_prevz = (ec == 0);
    @(posedge clk);
    #1;
    check(cmd_valid === m_mv, "R1 cmd_valid", 32'(cmd_valid), 32'(m_mv));
    if (m_mv) begin
      check(cmd_method === e_meth, "R2 cmd_method", 32'(cmd_method), 32'(e_meth));
      check(cmd_sub === e_sub, "R1 cmd_sub", 32'(cmd_sub), 32'(e_sub));
      check(cmd_hold === e_hold, "R1 cmd_hold", 32'(cmd_hold), 32'(e_hold));
      check(cmd_param === e_param, "R1 cmd_param", cmd_param, e_param);
    end
    check(irq === m_irq, "R8 irq", 32'(irq), 32'(m_irq));
    check(reg_rdata === exp_rd, "R13 reg_rdata", reg_rdata, exp_rd);
  endtask

  task automatic idle(input bit [1:0] ad, input bit rdy);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, ad, 0, rdy);
  endtask

  task automatic wreg(input bit [1:0] ad, input bit [31:0] v);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, ad, v, 1);
  endtask

  task automatic push(input bit [31:0] w, input bit rdy);
    cyc(1, w, 0, 0, 0, 0, 0, 0, 2'd3, 0, rdy);
  endtask

  task automatic load(input bit [13:0] a, input bit [2:0] s, input bit h);
    cyc(0, 0, 1, a, s, h, 0, 0, 2'd1, 0, 1);
  endtask

  initial begin
    int cnt = 0;
    while (!finished) begin
      @(posedge clk);
      cnt++;
      if (cnt > 200000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cnt, 200000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    check(cmd_valid === 1'b0, "R10 cmd_valid after reset", 32'(cmd_valid), 0);
    check(irq === 1'b0, "R10 irq after reset", 32'(irq), 0);
    check(word_ready === 1'b0, "R10 word_ready after reset", 32'(word_ready), 0);
    idle(2'd1, 1);
    check(reg_rdata === 32'h100, "R10 R5 push reg after reset", reg_rdata, 32'h100);
    idle(2'd3, 1);
    check(reg_rdata === 32'h0, "R10 shadow after reset", reg_rdata, 0);

    // enable, then R2 wrap
    wreg(2'd0, 1);
    wreg(2'd1, 1);
    load(14'h3FF8, 3'd5, 0);
    push(32'hA0A0_0001, 1);
    check(cmd_method === 14'h3FF8 && cmd_sub === 3'd5, "R12 loaded method state",
          32'(cmd_method), 32'h3FF8);
    push(32'hA0A0_0002, 1);
    check(cmd_method === 14'h3FFC, "R2 step by 4", 32'(cmd_method), 32'h3FFC);
    push(32'hA0A0_0003, 1);
    check(cmd_method === 14'h0000, "R2 wrap to zero", 32'(cmd_method), 0);

    // R2 hold
    load(14'h0100, 3'd2, 1);
    push(32'hB0B0_0001, 1);
    push(32'hB0B0_0002, 1);
    check(cmd_method === 14'h0100 && cmd_hold === 1'b1, "R2 hold keeps address",
          32'(cmd_method), 32'h100);

    // R9 backpressure
    load(14'h0200, 3'd1, 0);
    push(32'hC0C0_0001, 0);
    push(32'hC0C0_0002, 0);
    check(cmd_param === 32'hC0C0_0001, "R9 entry held under backpressure",
          cmd_param, 32'hC0C0_0001);
    push(32'hC0C0_0003, 1);
    check(cmd_method === 14'h0204 && cmd_param === 32'hC0C0_0003,
          "R9 no advance while stalled", 32'(cmd_method), 32'h204);
    idle(2'd1, 1);

    // R4 error event
    cyc(0, 0, 0, 0, 0, 0, 3'd1, 0, 2'd1, 0, 1);
    check(irq === 1'b1, "R4 irq raised", 32'(irq), 1);
    idle(2'd1, 1);
    check(reg_rdata === 32'h1101, "R5 suspended readback", reg_rdata, 32'h1101);
    push(32'hDEAD_0001, 1);
    check(cmd_valid === 1'b0, "R3 word ignored while suspended", 32'(cmd_valid), 0);
    idle(2'd3, 1);
    check(reg_rdata === 32'hC0C0_0003, "R7 shadow unchanged", reg_rdata, 32'hC0C0_0003);

    // R8 W1C
    wreg(2'd2, 0);
    check(irq === 1'b1, "R8 write 0 keeps irq", 32'(irq), 1);
    wreg(2'd2, 1);
    check(irq === 1'b0, "R8 write 1 clears irq", 32'(irq), 0);

    // R6 resume
    wreg(2'd1, 1);
    push(32'hE0E0_0001, 1);
    check(cmd_valid === 1'b1 && cmd_param === 32'hE0E0_0001, "R6 resume pushes",
          cmd_param, 32'hE0E0_0001);
    idle(2'd3, 1);
    check(reg_rdata === 32'hE0E0_0001, "R7 shadow last word", reg_rdata, 32'hE0E0_0001);

    // R11 error beats same-cycle clear
    cyc(0, 0, 0, 0, 0, 0, 3'd2, 0, 2'd0, 0, 1);
    wreg(2'd1, 1);
    idle(2'd0, 1);
    cyc(0, 0, 0, 0, 0, 0, 3'd2, 1, 2'd1, 32'h1, 1);
    idle(2'd1, 1);
    check(reg_rdata[12] === 1'b1, "R11 error wins over clear", 32'(reg_rdata[12]), 1);
    wreg(2'd2, 1);
    wreg(2'd1, 1);

    // R6 software force suspend
    wreg(2'd1, 32'h1001);
    idle(2'd1, 1);
    check(reg_rdata[12] === 1'b1, "R6 forced suspend", 32'(reg_rdata[12]), 1);
    wreg(2'd1, 1);

    // R12 load blocks ready
    cyc(1, 32'hF0F0_0001, 1, 14'h0040, 3'd3, 0, 0, 0, 2'd0, 0, 1);
    check(cmd_valid === 1'b0, "R12 no accept during load", 32'(cmd_valid), 0);

    // R13 push enable register
    wreg(2'd0, 0);
    idle(2'd0, 1);
    check(reg_rdata === 32'h0, "R13 push enable readback", reg_rdata, 0);
    wreg(2'd0, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit        wv, ld, lh, wr, rdy;
      bit [2:0]  ec, ls;
      bit [1:0]  ad;
      bit [31:0] wd, wdat;
      wv  = ($urandom % 4) != 0;
      wd  = $urandom;
      ld  = ($urandom % 10) == 0;
      ls  = 3'($urandom);
      lh  = ($urandom % 3) == 0;
      ec  = (($urandom % 40) == 0) ? 3'($urandom % 7 + 1) : 3'd0;
      wr  = ($urandom % 12) == 0;
      ad  = 2'($urandom);
      wdat = $urandom;
      if (wr && ad == 2'd1 && ($urandom % 4) != 0) wdat = 32'h1;
      if (wr && ad == 2'd0) wdat = ($urandom % 5) != 0 ? 32'h1 : 32'h0;
      rdy = ($urandom % 3) != 0;
      cyc(wv, wd, ld, 14'($urandom), ls, lh, ec, wr, ad, wdat, rdy);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule